// File: doc/BRIEF.md
# Vectorised Instruction Expander

The expander sits between instruction decode and the execution queue. Each accepted instruction carries an opcode tag and three register indices: destination, first source and second source. A 32-entry flag map, one bit per architectural register, says which registers are vectorised. A single vector length register (VL) holds the element count, and it applies to every operand. An instruction that names at least one vectorised register turns into VL element instructions. For element i, each vectorised operand uses its base index plus i, and each scalar operand keeps its index. The elements enter an output FIFO in increasing order, one per cycle.

VL is written by a set-length command, which is a third instruction kind. The command clamps the requested count to the `MAXVL` parameter and reports the clamped value. A jump-through-register instruction whose target register is vectorised raises an exception and produces nothing. So does any instruction whose expansion would carry a vectorised index past register 31, because indices never wrap. Instructions with no vectorised operand pass through as one unchanged element. A new instruction is taken only when the previous expansion has fully entered the FIFO.

Top module: `vec_expander`

## Requirements
- R1: After synchronous reset, VL is 1, `in_ready` is high, `out_valid` is low and no exception or length report is pending.
- R2: A set-length command (`in_kind` = 2) sets VL to min(`in_avl`, MAXVL). In the cycle after it is accepted, `len_valid` pulses once with that same value. VL keeps this value until the next set-length command.
- R3: A three-operand instruction (`in_kind` = 0) with at least one vectorised operand produces VL elements. Element i has the unchanged tag, each vectorised operand's index plus i, and each scalar operand's index unchanged.
- R4: A three-operand instruction with no vectorised operand produces exactly one element equal to the input, whatever VL is, including VL = 0.
- R5: A jump-register instruction (`in_kind` = 1) whose first source is vectorised produces no element and raises `exc_valid` with cause 1 in the cycle after acceptance. Otherwise it produces one unchanged element.
- R6: If any vectorised operand of a three-operand instruction has index + VL > 32, the instruction produces no element and raises `exc_valid` with cause 2 in the cycle after acceptance. index + VL = 32 is legal.
- R7: With VL = 0, a three-operand instruction that has a vectorised operand produces no element and raises no exception.
- R8: Elements leave the FIFO in the order they were generated. Generation stalls while the FIFO is full. While `out_valid` is high and `out_ready` is low, the head element is held unchanged.
- R9: `in_ready` goes low in the cycle after an instruction that produces elements is accepted. It stays low until the cycle after that instruction's last element has entered the FIFO. Set-length commands and excepting instructions leave `in_ready` high.
- R10: `in_kind` = 3 behaves exactly like a three-operand instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_map | input | 32 | Per-register vectorised flag, bit n for register n |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Expander can accept an instruction |
| in_kind | input | 2 | 0 three-operand, 1 jump-register, 2 set-length, 3 three-operand |
| in_tag | input | 4 | Opcode tag carried to every element |
| in_rd | input | 5 | Destination register index |
| in_rs1 | input | 5 | First source index (jump target for kind 1) |
| in_rs2 | input | 5 | Second source index |
| in_avl | input | AVLW | Requested element count for a set-length command |
| out_valid | output | 1 | FIFO head element valid |
| out_ready | input | 1 | Consumer takes the head element |
| out_tag | output | 4 | Element opcode tag |
| out_rd | output | 5 | Element destination index |
| out_rs1 | output | 5 | Element first source index |
| out_rs2 | output | 5 | Element second source index |
| exc_valid | output | 1 | Exception pulse for the previously accepted instruction |
| exc_cause | output | 2 | 1 vectorised jump target, 2 index range overrun |
| len_valid | output | 1 | Set-length result pulse |
| len_value | output | VLW | Clamped length written by the set-length command |
| vl | output | VLW | Current vector length |

## Verification
The bench builds the block with a FIFO only two entries deep and MAXVL at 8. An 8-element expansion therefore spends most of its time stalled behind a full queue. This exercises the hold of the generator's element counter and the low `in_ready` window. The bench also drives throttled consumer patterns, including a long all-stop phase and a one-in-three gap pattern. With MAXVL at 8, register 24 lands exactly on the last legal index, and registers 28 and 30 step over it. This covers both sides of the range boundary, as well as clamping of a requested count of 200.

// File: rtl/vexp_pkg.sv
package vexp_pkg;

    localparam int NREG = 32;
    localparam int RIDX = $clog2(NREG);
    localparam int TAGW = 4;

    typedef logic [RIDX-1:0] reg_t;

    typedef enum logic [1:0] {
        K_ALU    = 2'd0,
        K_JREG   = 2'd1,
        K_SETLEN = 2'd2,
        K_ALT    = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        EXC_NONE  = 2'd0,
        EXC_VJUMP = 2'd1,
        EXC_RANGE = 2'd2
    } exc_e;

    typedef struct packed {
        logic [TAGW-1:0] tag;
        reg_t            rd;
        reg_t            rs1;
        reg_t            rs2;
    } elem_t;

    // True when a run of n registers starting at r stays inside the file,
    // or when the operand is scalar and never advances.
    function automatic logic span_ok(reg_t r, logic is_vec, int n);
        return !is_vec || (int'(r) + n <= NREG);
    endfunction

endpackage

// File: rtl/vexp_len_reg.sv
module vexp_len_reg
    import vexp_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int AVLW  = 8,
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            set_en,
    input  logic [AVLW-1:0] set_avl,
    output logic [VLW-1:0]  vl,
    output logic            len_valid,
    output logic [VLW-1:0]  len_value
);

    logic [VLW-1:0] clamped;

    always_comb begin
        if (set_avl > AVLW'(MAXVL)) clamped = VLW'(MAXVL);
        else                        clamped = VLW'(set_avl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vl        <= VLW'(1);
            len_valid <= 1'b0;
            len_value <= '0;
        end else begin
            len_valid <= set_en;
            if (set_en) begin
                vl        <= clamped;
                len_value <= clamped;
            end
        end
    end

    assert_vl_bound_R2: assert property (@(posedge clk) disable iff (rst)
        int'(vl) <= MAXVL);

    assert_len_match_R2: assert property (@(posedge clk) disable iff (rst)
        len_valid |-> (len_value == vl));

endmodule

// File: rtl/vexp_seq.sv
module vexp_seq
    import vexp_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NREG-1:0] vec_map,
    input  logic [VLW-1:0]  vl,
    input  logic            in_valid,
    input  kind_e           in_kind,
    input  elem_t           in_el,
    output logic            in_ready,
    output logic            set_en,
    output logic            el_valid,
    output elem_t           el_data,
    input  logic            el_take,
    output logic            exc_valid,
    output exc_e            exc_cause
);

    logic           busy;
    elem_t          base;
    logic [2:0]     vflag;      // {rd, rs1, rs2}
    logic [VLW-1:0] idx;
    logic [VLW-1:0] last;

    logic           acc;
    logic           f_rd, f_rs1, f_rs2, any_vec, span_bad;
    logic           st_go;
    logic [2:0]     st_flags;
    logic [VLW-1:0] st_last;
    exc_e           exc_n;
    logic           push;
    logic [VLW-1:0] step;

    assign in_ready = !busy;
    assign acc      = in_valid && !busy;
    assign set_en   = acc && (in_kind == K_SETLEN);

    always_comb begin
        f_rd     = vec_map[in_el.rd];
        f_rs1    = vec_map[in_el.rs1];
        f_rs2    = vec_map[in_el.rs2];
        any_vec  = f_rd | f_rs1 | f_rs2;
        span_bad = !span_ok(in_el.rd,  f_rd,  int'(vl)) ||
                   !span_ok(in_el.rs1, f_rs1, int'(vl)) ||
                   !span_ok(in_el.rs2, f_rs2, int'(vl));
    end

    always_comb begin
        st_go    = 1'b0;
        st_flags = 3'b000;
        st_last  = '0;
        exc_n    = EXC_NONE;
        if (acc) begin
            case (in_kind)
                K_JREG: begin
                    if (f_rs1) exc_n = EXC_VJUMP;
                    else       st_go = 1'b1;
                end
                K_SETLEN: ;
                default: begin
                    if (!any_vec) begin
                        st_go = 1'b1;
                    end else if (span_bad) begin
                        exc_n = EXC_RANGE;
                    end else if (vl != '0) begin
                        st_go    = 1'b1;
                        st_flags = {f_rd, f_rs1, f_rs2};
                        st_last  = vl - VLW'(1);
                    end
                end
            endcase
        end
    end

    assign push     = busy && el_take;
    assign el_valid = busy;
    assign step     = idx;

    always_comb begin
        el_data     = base;
        el_data.rd  = base.rd  + (vflag[2] ? RIDX'(step) : '0);
        el_data.rs1 = base.rs1 + (vflag[1] ? RIDX'(step) : '0);
        el_data.rs2 = base.rs2 + (vflag[0] ? RIDX'(step) : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            base      <= '0;
            vflag     <= 3'b000;
            idx       <= '0;
            last      <= '0;
            exc_valid <= 1'b0;
            exc_cause <= EXC_NONE;
        end else begin
            exc_valid <= (exc_n != EXC_NONE);
            exc_cause <= exc_n;
            if (st_go) begin
                busy  <= 1'b1;
                base  <= in_el;
                vflag <= st_flags;
                idx   <= '0;
                last  <= st_last;
            end else if (push) begin
                if (idx == last) busy <= 1'b0;
                else             idx  <= idx + VLW'(1);
            end
        end
    end

    assert_exc_after_accept_R5: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> $past(acc));

    assert_range_keeps_ready_R6: assert property (@(posedge clk) disable iff (rst)
        (acc && (in_kind == K_ALU || in_kind == K_ALT) && any_vec && span_bad) |=> in_ready);

    assert_stall_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && !el_take) |=> (busy && $stable(idx)));

endmodule

// File: rtl/vexp_fifo.sv
module vexp_fifo
    import vexp_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  elem_t din,
    output logic  full,
    output logic  out_valid,
    input  logic  out_ready,
    output elem_t dout
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    elem_t         mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          pop;

    assign full      = (cnt == CW'(DEPTH));
    assign out_valid = (cnt != '0);
    assign dout      = mem[rp];
    assign pop       = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
            if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= DEPTH);

    assert_head_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(dout)));

endmodule

// File: rtl/vec_expander.sv
module vec_expander
    import vexp_pkg::*;
#(
    parameter int MAXVL = 8,
    parameter int DEPTH = 4,
    parameter int AVLW  = 8,
    localparam int VLW  = $clog2(MAXVL + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [31:0]     vec_map,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [1:0]      in_kind,
    input  logic [3:0]      in_tag,
    input  logic [4:0]      in_rd,
    input  logic [4:0]      in_rs1,
    input  logic [4:0]      in_rs2,
    input  logic [AVLW-1:0] in_avl,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [3:0]      out_tag,
    output logic [4:0]      out_rd,
    output logic [4:0]      out_rs1,
    output logic [4:0]      out_rs2,
    output logic            exc_valid,
    output logic [1:0]      exc_cause,
    output logic            len_valid,
    output logic [VLW-1:0]  len_value,
    output logic [VLW-1:0]  vl
);

    elem_t in_el, el_data, head;
    logic  set_en, el_valid, full;
    exc_e  cause;

    always_comb begin
        in_el.tag = in_tag;
        in_el.rd  = in_rd;
        in_el.rs1 = in_rs1;
        in_el.rs2 = in_rs2;
    end

    vexp_len_reg #(.MAXVL(MAXVL), .AVLW(AVLW), .VLW(VLW)) u_len (
        .clk       (clk),
        .rst       (rst),
        .set_en    (set_en),
        .set_avl   (in_avl),
        .vl        (vl),
        .len_valid (len_valid),
        .len_value (len_value)
    );

    vexp_seq #(.MAXVL(MAXVL), .VLW(VLW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .vec_map   (vec_map),
        .vl        (vl),
        .in_valid  (in_valid),
        .in_kind   (kind_e'(in_kind)),
        .in_el     (in_el),
        .in_ready  (in_ready),
        .set_en    (set_en),
        .el_valid  (el_valid),
        .el_data   (el_data),
        .el_take   (!full),
        .exc_valid (exc_valid),
        .exc_cause (cause)
    );

    vexp_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (el_valid && !full),
        .din       (el_data),
        .full      (full),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .dout      (head)
    );

    assign exc_cause = cause;
    assign out_tag   = head.tag;
    assign out_rd    = head.rd;
    assign out_rs1   = head.rs1;
    assign out_rs2   = head.rs2;

endmodule

// File: tb/vec_expander_tb.sv
`timescale 1ns/1ps
module vec_expander_tb;

    localparam int MAXVL = 8;
    localparam int DEPTH = 2;
    localparam int AVLW  = 8;
    localparam int VLW   = $clog2(MAXVL + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [31:0]     vec_map;
    logic            in_valid, in_ready, out_valid, out_ready;
    logic [1:0]      in_kind, exc_cause;
    logic [3:0]      in_tag, out_tag;
    logic [4:0]      in_rd, in_rs1, in_rs2, out_rd, out_rs1, out_rs2;
    logic [AVLW-1:0] in_avl;
    logic            exc_valid, len_valid;
    logic [VLW-1:0]  len_value, vl;

    vec_expander #(.MAXVL(MAXVL), .DEPTH(DEPTH), .AVLW(AVLW)) u_dut (
        .clk(clk), .rst(rst), .vec_map(vec_map),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind),
        .in_tag(in_tag), .in_rd(in_rd), .in_rs1(in_rs1), .in_rs2(in_rs2),
        .in_avl(in_avl), .out_valid(out_valid), .out_ready(out_ready),
        .out_tag(out_tag), .out_rd(out_rd), .out_rs1(out_rs1), .out_rs2(out_rs2),
        .exc_valid(exc_valid), .exc_cause(exc_cause),
        .len_valid(len_valid), .len_value(len_value), .vl(vl)
    );

    typedef struct {
        logic [18:0] e;
        string       r;
    } ex_t;

    ex_t   sq[$];
    ex_t   fq[$];
    int    m_vl;
    bit    m_exc_v;
    int    m_exc_c;
    string m_exc_r;
    bit    m_len_v;
    int    m_len;
    int    checks = 0;
    int    failures = 0;
    int    ready_mode = 0;
    int    cyc = 0;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [18:0] pack(int t, int d, int a, int b);
        return {4'(t), 5'(d), 5'(a), 5'(b)};
    endfunction

    task automatic model_accept();
        int k;
        bit fr, f1, f2;
        string r;
        k  = int'(in_kind);
        fr = vec_map[in_rd];
        f1 = vec_map[in_rs1];
        f2 = vec_map[in_rs2];
        m_exc_r = "R6";
        if (k == 2) begin
            m_len   = (int'(in_avl) > MAXVL) ? MAXVL : int'(in_avl);
            m_len_v = 1'b1;
            m_vl    = m_len;
            m_exc_r = "R2";
        end else if (k == 1) begin
            m_exc_r = "R5";
            if (f1) begin
                m_exc_v = 1'b1;
                m_exc_c = 1;
            end else begin
                sq.push_back('{pack(in_tag, in_rd, in_rs1, in_rs2), "R5"});
            end
        end else begin
            r = (k == 3) ? "R10" : "R3";
            if (!(fr || f1 || f2)) begin
                m_exc_r = (k == 3) ? "R10" : "R4";
                sq.push_back('{pack(in_tag, in_rd, in_rs1, in_rs2), m_exc_r});
            end else if ((fr && int'(in_rd) + m_vl > 32) ||
                         (f1 && int'(in_rs1) + m_vl > 32) ||
                         (f2 && int'(in_rs2) + m_vl > 32)) begin
                m_exc_v = 1'b1;
                m_exc_c = 2;
                m_exc_r = "R6";
            end else begin
                m_exc_r = (m_vl == 0) ? "R7" : r;
                for (int i = 0; i < m_vl; i++) begin
                    sq.push_back('{pack(in_tag,
                                        int'(in_rd)  + (fr ? i : 0),
                                        int'(in_rs1) + (f1 ? i : 0),
                                        int'(in_rs2) + (f2 ? i : 0)), r});
                end
            end
        end
    endtask

    // Reference model: advances once per rising edge from the sampled inputs.
    always @(posedge clk) begin
        bit do_pop, do_push, do_acc;
        cyc++;
        if (rst) begin
            sq.delete();
            fq.delete();
            m_vl    = 1;
            m_exc_v = 1'b0;
            m_exc_c = 0;
            m_exc_r = "R1";
            m_len_v = 1'b0;
            m_len   = 0;
        end else begin
            do_pop  = (fq.size() > 0) && out_ready;
            do_push = (sq.size() > 0) && (fq.size() < DEPTH);
            do_acc  = (sq.size() == 0) && in_valid;
            m_exc_v = 1'b0;
            m_len_v = 1'b0;
            if (do_pop)  void'(fq.pop_front());
            if (do_push) fq.push_back(sq.pop_front());
            if (do_acc)  model_accept();
        end
    end

    // Compare every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (!rst) begin
            chk(in_ready == (sq.size() == 0), "R9", "in_ready", in_ready, sq.size() == 0);
            chk(out_valid == (fq.size() > 0), "R8", "out_valid", out_valid, fq.size() > 0);
            if (out_valid && fq.size() > 0)
                chk({out_tag, out_rd, out_rs1, out_rs2} == fq[0].e, fq[0].r, "element",
                    {out_tag, out_rd, out_rs1, out_rs2}, fq[0].e);
            chk(exc_valid == m_exc_v, m_exc_r, "exc_valid", exc_valid, m_exc_v);
            if (exc_valid && m_exc_v)
                chk(int'(exc_cause) == m_exc_c, m_exc_r, "exc_cause", exc_cause, m_exc_c);
            chk(len_valid == m_len_v, "R2", "len_valid", len_valid, m_len_v);
            if (m_len_v)
                chk(int'(len_value) == m_len, "R2", "len_value", len_value, m_len);
            chk(int'(vl) == m_vl, "R2", "vl", vl, m_vl);
        end
    end

    always @(negedge clk) begin
        #1;
        case (ready_mode)
            1:       out_ready = 1'b0;
            2:       out_ready = (cyc % 3) != 0;
            3:       out_ready = cyc[0];
            default: out_ready = 1'b1;
        endcase
    end

    task automatic issue(int k, int tag, int rd, int r1, int r2, int avl);
        bit done;
        done = 1'b0;
        while (!done) begin
            @(negedge clk);
            #1;
            in_valid = 1'b1;
            in_kind  = 2'(k);
            in_tag   = 4'(tag);
            in_rd    = 5'(rd);
            in_rs1   = 5'(r1);
            in_rs2   = 5'(r2);
            in_avl   = AVLW'(avl);
            if (in_ready) begin
                @(posedge clk);
                done = 1'b1;
            end
        end
        @(negedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic setlen(int avl);
        issue(2, 0, 0, 0, 0, avl);
    endtask

    task automatic drain();
        ready_mode = 0;
        while (sq.size() != 0 || fq.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        vec_map   = '0;
        in_valid  = 1'b0;
        in_kind   = '0;
        in_tag    = '0;
        in_rd     = '0;
        in_rs1    = '0;
        in_rs2    = '0;
        in_avl    = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(int'(vl) == 1, "R1", "vl after reset", vl, 1);
        chk(exc_valid == 1'b0 && len_valid == 1'b0, "R1", "pulses after reset",
            {exc_valid, len_valid}, 0);

        // R2 + R3: all operands vectorised, VL=3
        setlen(3);
        vec_map = (32'd1 << 7) | (32'd1 << 4);
        issue(0, 1, 7, 4, 4, 0);
        // R3: first source scalar
        vec_map = (32'd1 << 7) | (32'd1 << 1);
        issue(0, 1, 7, 4, 1, 0);
        drain();

        // R4: nothing vectorised
        vec_map = '0;
        issue(0, 3, 5, 6, 7, 0);
        // R5: jump with vectorised target, then scalar target
        vec_map = 32'd1 << 9;
        issue(1, 2, 1, 9, 0, 0);
        issue(1, 2, 9, 8, 0, 0);
        drain();

        // R6: range boundary with VL=8
        setlen(8);
        vec_map = 32'd1 << 28;
        issue(0, 6, 28, 3, 3, 0);
        vec_map = 32'd1 << 24;
        issue(0, 6, 24, 3, 3, 0);
        drain();
        setlen(2);
        vec_map = 32'd1 << 30;
        issue(0, 8, 1, 2, 30, 0);
        setlen(3);
        issue(0, 8, 1, 2, 30, 0);
        drain();

        // R2 clamp, R7 VL=0, R4 at VL=0
        setlen(200);
        setlen(0);
        vec_map = 32'd1 << 3;
        issue(0, 7, 3, 3, 3, 0);
        vec_map = '0;
        issue(0, 7, 1, 2, 2, 0);
        drain();

        // R8: consumer stopped during a long expansion
        setlen(8);
        vec_map = 32'd1 << 10;
        ready_mode = 1;
        issue(0, 5, 10, 0, 0, 0);
        repeat (12) @(negedge clk);
        drain();

        // R10: alternate three-operand code, throttled consumer
        setlen(4);
        vec_map = (32'd1 << 12) | (32'd1 << 2);
        ready_mode = 2;
        issue(3, 9, 12, 1, 2, 0);
        issue(3, 10, 4, 5, 6, 0);
        ready_mode = 3;
        issue(0, 11, 12, 12, 20, 0);
        issue(1, 12, 0, 2, 0, 0);
        setlen(5);
        issue(0, 13, 2, 13, 12, 0);
        drain();

        chk(sq.size() == 0 && fq.size() == 0, "R8", "all elements delivered",
            sq.size() + fq.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule